// File: doc/BRIEF.md
# Windowed Bus Address Translation Unit

This unit sits inside a bus bridge and rewrites addresses that cross it. Four outbound windows turn processor addresses into bus addresses, and three inbound windows turn bus addresses into local memory addresses. Each window has a base page, a translation page, and an attribute word. The attribute word holds an enable bit and a size code. All other attribute bits are kept and read back but have no effect.

Software sets up the windows through a word-wide register port. This port is a 12-bit offset, a write strobe, write data, and combinational read data. Two independent lookup ports work at the same time, one per direction. Each takes a 64-bit address and returns, in the same cycle, a hit flag, the winning window index and the rewritten address. A register write changes lookups from the cycle after the clock edge that stores it.

Top module: `bus_xlat_unit`

## Requirements
- R1: After reset every register reads zero, and neither lookup port reports a hit.
- R2: Outbound windows are decoded at offsets 0x020, 0x040, 0x060 and 0x080. Their indices are 1 to 4, taken from offset bits [7:5]. Inside each group, the word at +0x0 is the translation page and +0x4 is the upper 32 bits of the translation page. The word at +0x8 is the base page and +0x10 is the attributes. Each word reads back what was written.
- R3: Inbound windows are decoded at offsets 0x1A0, 0x1C0 and 0x1E0. Their indices are 0 to 2, equal to offset bits [6:5] minus one. Inside each group, the word at +0x0 is the translation page and +0x8 is the base page. The word at +0xC is the upper 32 bits of the base page and +0x10 is the attributes. Each word reads back what was written.
- R4: A read returns zero at any offset outside those groups and the timer group, and at any unlisted word inside a window group. Writes to such offsets change no register and no lookup result.
- R5: The group at offset 0x220 holds a 32-bit timer value. It reads back whatever was last written and does not affect lookups.
- R6: A window whose attribute bit 31 is 0 never hits.
- R7: A window spans 2 << (attribute bits [5:0]) bytes. The code 63 covers the whole 64-bit space.
- R8: Page values are shifted left by 12 to give byte addresses. For outbound windows the translation page is {upper word, lower word}. For inbound windows the base page is {upper word, lower word}. On a hit the output address is translation + (address − base), modulo 2^64.
- R9: A window hits when base ≤ address < base + size.
- R10: When several enabled windows of one direction hit, the lowest index wins.
- R11: On a miss the hit flag is 0, the index is 0 and the address passes through unchanged.
- R12: A write to a window register changes lookups starting in the cycle after the clock edge that stores it. During the write cycle the old setting still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_off | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_off (combinational) |
| ob_addr | input | 64 | Outbound lookup address |
| ob_hit | output | 1 | Outbound hit |
| ob_idx | output | 3 | Winning outbound window index (1 to 4, 0 on a miss) |
| ob_xaddr | output | 64 | Outbound translated address |
| ib_addr | input | 64 | Inbound lookup address |
| ib_hit | output | 1 | Inbound hit |
| ib_idx | output | 2 | Winning inbound window index (0 to 2) |
| ib_xaddr | output | 64 | Inbound translated address |

## Verification
A wrongly stored field shows up in the same cycle on two ports: as a wrong read-back value on reg_rdata, and as a wrong hit, index or offset on the lookup port once an address is sent into that window. Decode errors show up the same way. An outbound group that lands in the wrong slot makes the wrong window answer. A bad inbound minus-one index makes a write land on a neighbour that reads back nonzero. Both appear on the first lookup or read after the write. Faults in the size and bound logic appear only at window edges, so the bench probes the last byte inside a window, the first byte past it, and a full-range window.

// File: rtl/bus_xlat_unit.sv
`timescale 1ns/1ps
module bus_xlat_unit #(
  parameter int NOB = 4,
  parameter int NIB = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] reg_off,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [63:0] ob_addr,
  output logic        ob_hit,
  output logic [2:0]  ob_idx,
  output logic [63:0] ob_xaddr,
  input  logic [63:0] ib_addr,
  output logic        ib_hit,
  output logic [1:0]  ib_idx,
  output logic [63:0] ib_xaddr
);
  logic [31:0] ob_tar [NOB], ob_tea [NOB], ob_bar [NOB], ob_war [NOB];
  logic [31:0] ib_tar [NIB], ib_bar [NIB], ib_bea [NIB], ib_war [NIB];
  logic [31:0] tmr;

  wire [11:0] grp  = reg_off & 12'hFE0;
  wire [4:0]  word = reg_off[4:0];
  wire ob_sel  = (grp == 12'h020) || (grp == 12'h040) || (grp == 12'h060) || (grp == 12'h080);
  wire ib_sel  = (grp == 12'h1A0) || (grp == 12'h1C0) || (grp == 12'h1E0);
  wire tmr_sel = (grp == 12'h220);
  wire [2:0] ob_wm = reg_off[7:5] - 3'd1;
  wire [1:0] ob_w  = ob_wm[1:0];
  wire [1:0] ib_w  = reg_off[6:5] - 2'd1;

  function automatic logic in_win(input logic [63:0] a, input logic [63:0] base,
                                  input logic [5:0] sz);
    logic [64:0] lim;
    lim = {1'b0, base} + (65'd2 << sz);
    return (a >= base) && ({1'b0, a} < lim);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NOB; i++) begin
        ob_tar[i] <= '0; ob_tea[i] <= '0; ob_bar[i] <= '0; ob_war[i] <= '0;
      end
      for (int i = 0; i < NIB; i++) begin
        ib_tar[i] <= '0; ib_bar[i] <= '0; ib_bea[i] <= '0; ib_war[i] <= '0;
      end
      tmr <= '0;
    end else if (reg_we) begin
      if (ob_sel) begin
        case (word)
          5'h00: ob_tar[ob_w] <= reg_wdata;
          5'h04: ob_tea[ob_w] <= reg_wdata;
          5'h08: ob_bar[ob_w] <= reg_wdata;
          5'h10: ob_war[ob_w] <= reg_wdata;
          default: ;
        endcase
      end else if (ib_sel) begin
        case (word)
          5'h00: ib_tar[ib_w] <= reg_wdata;
          5'h08: ib_bar[ib_w] <= reg_wdata;
          5'h0C: ib_bea[ib_w] <= reg_wdata;
          5'h10: ib_war[ib_w] <= reg_wdata;
          default: ;
        endcase
      end else if (tmr_sel) begin
        tmr <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ob_sel) begin
      case (word)
        5'h00: reg_rdata = ob_tar[ob_w];
        5'h04: reg_rdata = ob_tea[ob_w];
        5'h08: reg_rdata = ob_bar[ob_w];
        5'h10: reg_rdata = ob_war[ob_w];
        default: ;
      endcase
    end else if (ib_sel) begin
      case (word)
        5'h00: reg_rdata = ib_tar[ib_w];
        5'h08: reg_rdata = ib_bar[ib_w];
        5'h0C: reg_rdata = ib_bea[ib_w];
        5'h10: reg_rdata = ib_war[ib_w];
        default: ;
      endcase
    end else if (tmr_sel) begin
      reg_rdata = tmr;
    end
  end

  always_comb begin
    logic [63:0] b, t;
    ob_hit = 1'b0; ob_idx = '0; ob_xaddr = ob_addr;
    for (int i = NOB - 1; i >= 0; i--) begin
      b = {32'h0, ob_bar[i]} << 12;
      t = {ob_tea[i], ob_tar[i]} << 12;
      if (ob_war[i][31] && in_win(ob_addr, b, ob_war[i][5:0])) begin
        ob_hit = 1'b1; ob_idx = 3'(i + 1); ob_xaddr = t + (ob_addr - b);
      end
    end
  end

  always_comb begin
    logic [63:0] b, t;
    ib_hit = 1'b0; ib_idx = '0; ib_xaddr = ib_addr;
    for (int i = NIB - 1; i >= 0; i--) begin
      b = {ib_bea[i], ib_bar[i]} << 12;
      t = {32'h0, ib_tar[i]} << 12;
      if (ib_war[i][31] && in_win(ib_addr, b, ib_war[i][5:0])) begin
        ib_hit = 1'b1; ib_idx = 2'(i); ib_xaddr = t + (ib_addr - b);
      end
    end
  end

  // R2
  ob_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ob_hit |-> (ob_idx >= 3'd1 && ob_idx <= 3'd4));
  // R3
  ib_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_hit |-> (ib_idx <= 2'd2));
  // R11
  ob_miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_hit |-> (ob_xaddr == ob_addr && ob_idx == 3'd0));
  // R11
  ib_miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_hit |-> (ib_xaddr == ib_addr && ib_idx == 2'd0));
  // R6
  ob_hit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ob_hit |-> ob_war[2'(ob_idx[1:0] - 2'd1)][31]);
  // R4
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ob_sel && !ib_sel && !tmr_sel) |-> (reg_rdata == 32'h0));
  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ob_war[0]) && $stable(ib_war[0]));
endmodule

// File: tb/bus_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module bus_xlat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_off = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] ob_addr = '0, ib_addr = '0;
  logic        ob_hit, ib_hit;
  logic [2:0]  ob_idx;
  logic [1:0]  ib_idx;
  logic [63:0] ob_xaddr, ib_xaddr;

  always #5 clk = ~clk;

  bus_xlat_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_addr(ob_addr), .ob_hit(ob_hit), .ob_idx(ob_idx), .ob_xaddr(ob_xaddr),
    .ib_addr(ib_addr), .ib_hit(ib_hit), .ib_idx(ib_idx), .ib_xaddr(ib_xaddr)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        hit;
    logic [2:0]  idx;
    logic [63:0] val;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int total = 0;
  int bad = 0;

  always @(negedge clk) begin
    if (eq.size() > 0) begin
      exp_t e;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      total++;
      case (e.kind)
        2'd0: if (ob_hit !== e.hit || ob_idx !== e.idx || ob_xaddr !== e.val) begin
          bad++;
          $display("FAIL %s: outbound hit=%0d idx=%0d x=%h expected hit=%0d idx=%0d x=%h",
                   t, ob_hit, ob_idx, ob_xaddr, e.hit, e.idx, e.val);
        end
        2'd1: if (ib_hit !== e.hit || ib_idx !== e.idx[1:0] || ib_xaddr !== e.val) begin
          bad++;
          $display("FAIL %s: inbound hit=%0d idx=%0d x=%h expected hit=%0d idx=%0d x=%h",
                   t, ib_hit, ib_idx, ib_xaddr, e.hit, e.idx, e.val);
        end
        default: if (reg_rdata !== e.val[31:0]) begin
          bad++;
          $display("FAIL %s: rdata=%h expected %h", t, reg_rdata, e.val[31:0]);
        end
      endcase
    end
  end

  task automatic push(input exp_t e, input string t);
    eq.push_back(e);
    tq.push_back(t);
  endtask

  task automatic wr(input logic [11:0] o, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_off = o; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] o, input logic [31:0] ex, input string t);
    @(posedge clk); #1;
    reg_off = o;
    push(exp_t'{kind: 2'd2, hit: 1'b0, idx: 3'd0, val: {32'h0, ex}}, t);
    @(negedge clk); #1;
  endtask

  task automatic ob(input logic [63:0] a, input logic h, input logic [2:0] i,
                    input logic [63:0] x, input string t);
    @(posedge clk); #1;
    ob_addr = a;
    push(exp_t'{kind: 2'd0, hit: h, idx: i, val: x}, t);
    @(negedge clk); #1;
  endtask

  task automatic ib(input logic [63:0] a, input logic h, input logic [1:0] i,
                    input logic [63:0] x, input string t);
    @(posedge clk); #1;
    ib_addr = a;
    push(exp_t'{kind: 2'd1, hit: h, idx: {1'b0, i}, val: x}, t);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(12'h030, 32'h0, "R1 outbound attr after reset");
    rd(12'h1A0, 32'h0, "R1 inbound translation after reset");
    ob(64'h0, 1'b0, 3'd0, 64'h0, "R1 outbound miss after reset");
    ib(64'h123, 1'b0, 2'd0, 64'h123, "R1 inbound miss after reset");

    // outbound window 1
    wr(12'h020, 32'h80);
    wr(12'h024, 32'h1);
    wr(12'h028, 32'h10);
    wr(12'h030, 32'h8000_000B);
    ob(64'h10010, 1'b1, 3'd1, 64'h1000_0008_0010, "R8 outbound extended translation");
    ob(64'h10FFF, 1'b1, 3'd1, 64'h1000_0008_0FFF, "R9 last byte inside window");
    ob(64'h11000, 1'b0, 3'd0, 64'h11000, "R9 first byte past window");
    ob(64'hFFFF, 1'b0, 3'd0, 64'hFFFF, "R11 below base passes through");
    rd(12'h024, 32'h1, "R2 outbound upper translation word readback");
    rd(12'h02C, 32'h0, "R4 unlisted outbound word reads zero");

    // outbound window 2 overlapping window 1
    wr(12'h040, 32'h200);
    wr(12'h048, 32'h10);
    wr(12'h050, 32'h8000_000F);
    ob(64'h10010, 1'b1, 3'd1, 64'h1000_0008_0010, "R10 lower index wins on overlap");
    ob(64'h11000, 1'b1, 3'd2, 64'h201000, "R7 size code 15 spans 64 KiB");
    wr(12'h030, 32'h0000_000B);
    ob(64'h10010, 1'b1, 3'd2, 64'h200010, "R6 disabled window never hits");
    rd(12'h030, 32'h0000_000B, "R2 attribute readback");

    // outbound window 4 with high base
    wr(12'h080, 32'h1);
    wr(12'h088, 32'hFFFF_FFFF);
    wr(12'h090, 32'h8000_000B);
    ob(64'h0FFF_FFFF_F123, 1'b1, 3'd4, 64'h1123, "R2 window at offset 0x080 is index 4");
    rd(12'h080, 32'h1, "R2 index 4 translation readback");

    // inbound windows
    wr(12'h1A0, 32'h100);
    wr(12'h1A8, 32'h0);
    wr(12'h1AC, 32'h2);
    wr(12'h1B0, 32'h8000_0013);
    ib(64'h2000_0000_0040, 1'b1, 2'd0, 64'h100040, "R3 inbound index 0 with extended base");
    wr(12'h1E0, 32'h300);
    wr(12'h1E8, 32'h5);
    wr(12'h1F0, 32'h8000_000B);
    ib(64'h5004, 1'b1, 2'd2, 64'h300004, "R3 inbound offset 0x1E0 is index 2");
    rd(12'h1E8, 32'h5, "R3 inbound base readback");
    rd(12'h1C8, 32'h0, "R3 index 1 untouched by neighbour writes");
    rd(12'h1A4, 32'h0, "R4 unlisted inbound word reads zero");
    ob(64'h5004, 1'b0, 3'd0, 64'h5004, "R11 outbound miss on inbound-only address");

    // full range inbound window 1
    wr(12'h1D0, 32'h8000_003F);
    ib(64'h5004, 1'b1, 2'd1, 64'h5004, "R10 inbound index 1 beats index 2");
    ib(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R7 size code 63 covers top address");
    ib(64'h2000_0000_0040, 1'b1, 2'd0, 64'h100040, "R10 inbound index 0 still first");

    // timer
    wr(12'h220, 32'hDEAD_BEEF);
    rd(12'h220, 32'hDEAD_BEEF, "R5 timer readback");
    ob(64'h11000, 1'b1, 3'd2, 64'h201000, "R5 timer write leaves lookups alone");

    // unmapped writes
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h0A0, 32'h8000_000B);
    wr(12'h180, 32'h8000_003F);
    rd(12'h000, 32'h0, "R4 offset 0x000 reads zero");
    rd(12'h0A0, 32'h0, "R4 offset 0x0A0 reads zero");
    rd(12'h180, 32'h0, "R4 offset 0x180 reads zero");
    ob(64'h10010, 1'b1, 3'd2, 64'h200010, "R4 unmapped writes leave outbound lookups");
    ib(64'h5004, 1'b1, 2'd1, 64'h5004, "R4 unmapped writes leave inbound lookups");

    // next-cycle effect, window 3
    wr(12'h060, 32'h50);
    wr(12'h068, 32'h40);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_off = 12'h070; reg_wdata = 32'h8000_000B; ob_addr = 64'h40008;
    push(exp_t'{kind: 2'd0, hit: 1'b0, idx: 3'd0, val: 64'h40008}, "R12 old setting during write cycle");
    @(negedge clk); #1;
    @(posedge clk); #1;
    reg_we = 1'b0;
    push(exp_t'{kind: 2'd0, hit: 1'b1, idx: 3'd3, val: 64'h50008}, "R12 new setting after write edge");
    @(negedge clk); #1;

    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule